// File: doc/BRIEF.md
# Bank-Switched Two-Port Word Memory

This block is a two-port word memory whose storage is split into four independent banks. Which port may use a bank is decided purely by one external select input per bank. A high select hands the bank to the left port and a low select hands it to the right port. Any split is allowed, from one port owning every bank to the other owning every bank. Both ports run at the same time as long as they work in different banks. Ownership needs no arbitration, because two ports can never own the same bank.

Each port carries a pair of chip enables, a read/write strobe, an output enable, two active-low byte enables, a bank number, an offset inside the bank, and separate write-data and read-data buses. Each port also has a mailbox select input. While that input is active the memory path of the port is closed.

Operation is synchronous. A request is sampled on a rising clock edge, and its read data and error flag are presented after that edge for one cycle. A port that reaches for a bank it does not own is blocked, and it gets zero data and an error pulse. A port that reaches for a bank whose select input has just changed is blocked in the same way. The offset width is a parameter: 13 gives 8K words per bank and 32K words in total. The default is kept smaller.

Top module: `bankmem_dp`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, both read-data outputs are zero and both error flags are low.
- R2: A bank whose select input is 1 belongs to the left port, and a bank whose select input is 0 belongs to the right port. A word written by the owning port is returned by a later read of the same bank and offset by that port.
- R3: The two ports may access two different banks in the same cycle, and neither access disturbs the other.
- R4: An access (read or write) to a bank the port does not own leaves memory unchanged. The port returns zero read data and raises its error flag for the cycle after the request.
- R5: A port is selected only when its active-low chip enable is 0 and its active-high chip enable is 1. Otherwise the request has no effect, reads zero and raises no error.
- R6: While a port's active-low mailbox select is 0, its memory request is ignored, even with both chip enables active. It writes nothing, reads zero and raises no error.
- R7: A write changes only the enabled bytes of the word: the upper byte (bits 15:8) when the upper enable is 0, and the lower byte (bits 7:0) when the lower enable is 0.
- R8: On a read, a byte whose enable is 1 reads back as zero. A request with both byte enables at 1 is no access, and it raises no error.
- R9: A read with the output enable at 1 returns zero data, and it raises no error when the bank is owned.
- R10: If a bank's select input differs from its value at the previous clock edge, an access to that bank in that cycle is dropped and flagged as an error. Accesses to other banks proceed normally.
- R11: Read data is valid exactly one clock after the request. In any cycle that follows a cycle without a read, the read data is zero.
- R12: A port address is a 2-bit bank number plus an offset within that bank. The same offset in different banks names different words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bank_sel | input | NB | Per-bank owner select: 1 left, 0 right |
| lp_ce_n | input | 1 | Left chip enable, active low |
| lp_ce | input | 1 | Left chip enable, active high |
| lp_mbx_n | input | 1 | Left mailbox select, active low (closes memory path) |
| lp_we_n | input | 1 | Left strobe: 0 write, 1 read |
| lp_oe_n | input | 1 | Left output enable, active low |
| lp_ub_n | input | 1 | Left upper byte enable, active low |
| lp_lb_n | input | 1 | Left lower byte enable, active low |
| lp_bank | input | BANK_W | Left bank number |
| lp_off | input | OFF_W | Left offset in bank |
| lp_wdata | input | DATA_W | Left write data |
| lp_rdata | output | DATA_W | Left read data |
| lp_err | output | 1 | Left access error pulse |
| rp_ce_n | input | 1 | Right chip enable, active low |
| rp_ce | input | 1 | Right chip enable, active high |
| rp_mbx_n | input | 1 | Right mailbox select, active low |
| rp_we_n | input | 1 | Right strobe: 0 write, 1 read |
| rp_oe_n | input | 1 | Right output enable, active low |
| rp_ub_n | input | 1 | Right upper byte enable, active low |
| rp_lb_n | input | 1 | Right lower byte enable, active low |
| rp_bank | input | BANK_W | Right bank number |
| rp_off | input | OFF_W | Right offset in bank |
| rp_wdata | input | DATA_W | Right write data |
| rp_rdata | output | DATA_W | Right read data |
| rp_err | output | 1 | Right access error pulse |

## Verification
The bench builds the block with four banks, 16-bit words and an offset width of 4, so each bank holds 16 words. With banks this small, every word can be filled with a known value at the start. Random traffic then revisits the same words again and again. This makes overwrites, byte merges and blocked accesses to words already holding data frequent events rather than rare ones. Occasional flips of single select bits under random traffic land on the bank being accessed often enough to exercise the ownership-change drop many times.

// File: rtl/bankmem_pkg.sv
package bankmem_pkg;

    // Byte lanes per word; lane 1 is the upper byte, lane 0 the lower byte.
    localparam int LANES = 2;

    // Decoded request of one port for the current cycle.
    typedef struct packed {
        logic             go;    // legal access, reaches a bank
        logic             wr;    // write when set, read otherwise
        logic             show;  // output enable active
        logic             err;   // access attempted but blocked
        logic [LANES-1:0] be;    // active-high byte lanes
    } port_req_t;

endpackage

// File: rtl/bankmem_port_dec.sv
module bankmem_port_dec
    import bankmem_pkg::*;
#(
    parameter int NB     = 4,
    parameter int BANK_W = 2
) (
    input  logic              ce_n,
    input  logic              ce,
    input  logic              mbx_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [BANK_W-1:0] bank,
    input  logic [NB-1:0]     owned,
    input  logic [NB-1:0]     moving,
    output port_req_t         req
);

    logic selected;
    logic touches;
    logic own_hit;
    logic in_motion;

    always_comb begin
        selected  = !ce_n && ce && mbx_n;
        touches   = selected && (!ub_n || !lb_n);
        own_hit   = owned[bank];
        in_motion = moving[bank];

        req.go   = touches && own_hit && !in_motion;
        req.err  = touches && (!own_hit || in_motion);
        req.wr   = !we_n;
        req.show = !oe_n;
        req.be   = {!ub_n, !lb_n};
    end

endmodule

// File: rtl/bankmem_bank.sv
module bankmem_bank
    import bankmem_pkg::*;
#(
    parameter int OFF_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [LANES-1:0]  be,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH  = 1 << OFF_W;
    localparam int LANE_W = DATA_W / LANES;

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } bank_st_t;

    logic [DATA_W-1:0] mem [DEPTH];
    bank_st_t          st_d;
    bank_st_t          st_q;

    // Byte-lane write port.
    always_ff @(posedge clk) begin
        if (en && wr) begin
            for (int g = 0; g < LANES; g++) begin
                if (be[g]) begin
                    mem[off][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Registered read word.
    always_comb begin
        st_d = st_q;
        if (en && !wr) begin
            st_d.word = mem[off];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.word;

endmodule

// File: rtl/bankmem_dp.sv
module bankmem_dp
    import bankmem_pkg::*;
#(
    parameter  int NB     = 4,
    parameter  int OFF_W  = 8,
    parameter  int DATA_W = 16,
    localparam int BANK_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     bank_sel,
    input  logic              lp_ce_n,
    input  logic              lp_ce,
    input  logic              lp_mbx_n,
    input  logic              lp_we_n,
    input  logic              lp_oe_n,
    input  logic              lp_ub_n,
    input  logic              lp_lb_n,
    input  logic [BANK_W-1:0] lp_bank,
    input  logic [OFF_W-1:0]  lp_off,
    input  logic [DATA_W-1:0] lp_wdata,
    output logic [DATA_W-1:0] lp_rdata,
    output logic              lp_err,
    input  logic              rp_ce_n,
    input  logic              rp_ce,
    input  logic              rp_mbx_n,
    input  logic              rp_we_n,
    input  logic              rp_oe_n,
    input  logic              rp_ub_n,
    input  logic              rp_lb_n,
    input  logic [BANK_W-1:0] rp_bank,
    input  logic [OFF_W-1:0]  rp_off,
    input  logic [DATA_W-1:0] rp_wdata,
    output logic [DATA_W-1:0] rp_rdata,
    output logic              rp_err
);

    localparam int NP     = 2;              // port 0 left, port 1 right
    localparam int LANE_W = DATA_W / LANES;

    typedef struct packed {
        logic [NB-1:0]                 sel;   // selects seen at last edge
        logic [NP-1:0]                 vld;   // read data due this cycle
        logic [NP-1:0]                 err;
        logic [NP-1:0][BANK_W-1:0]     bank;
        logic [NP-1:0][LANES-1:0]      be;
    } top_st_t;

    top_st_t st_d;
    top_st_t st_q;

    // Port inputs gathered into arrays indexed by port.
    logic [NP-1:0]             ce_n_a, ce_a, mbx_n_a, we_n_a, oe_n_a, ub_n_a, lb_n_a;
    logic [NP-1:0][BANK_W-1:0] bank_a;
    logic [NP-1:0][OFF_W-1:0]  off_a;
    logic [NP-1:0][DATA_W-1:0] wdata_a;
    logic [NP-1:0][DATA_W-1:0] rdata_a;
    logic [NP-1:0][NB-1:0]     owned_a;
    logic [NB-1:0]             moving;
    port_req_t                 req [NP];
    logic [DATA_W-1:0]         bank_rd [NB];

    assign ce_n_a  = {rp_ce_n,  lp_ce_n};
    assign ce_a    = {rp_ce,    lp_ce};
    assign mbx_n_a = {rp_mbx_n, lp_mbx_n};
    assign we_n_a  = {rp_we_n,  lp_we_n};
    assign oe_n_a  = {rp_oe_n,  lp_oe_n};
    assign ub_n_a  = {rp_ub_n,  lp_ub_n};
    assign lb_n_a  = {rp_lb_n,  lp_lb_n};
    assign bank_a  = {rp_bank,  lp_bank};
    assign off_a   = {rp_off,   lp_off};
    assign wdata_a = {rp_wdata, lp_wdata};

    // Ownership: select high gives the left port, low the right port.
    assign owned_a[0] = bank_sel;
    assign owned_a[1] = ~bank_sel;
    assign moving     = bank_sel ^ st_q.sel;

    for (genvar p = 0; p < NP; p++) begin : g_port
        bankmem_port_dec #(
            .NB     (NB),
            .BANK_W (BANK_W)
        ) i_dec (
            .ce_n   (ce_n_a[p]),
            .ce     (ce_a[p]),
            .mbx_n  (mbx_n_a[p]),
            .we_n   (we_n_a[p]),
            .oe_n   (oe_n_a[p]),
            .ub_n   (ub_n_a[p]),
            .lb_n   (lb_n_a[p]),
            .bank   (bank_a[p]),
            .owned  (owned_a[p]),
            .moving (moving),
            .req    (req[p])
        );
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic              pick;
        logic              b_en;
        logic              b_wr;
        logic [LANES-1:0]  b_be;
        logic [OFF_W-1:0]  b_off;
        logic [DATA_W-1:0] b_wdata;

        // The owner is the only port that can route into this bank.
        always_comb begin
            pick    = ~bank_sel[b];
            b_en    = req[pick].go && (bank_a[pick] == BANK_W'(b));
            b_wr    = req[pick].wr;
            b_be    = req[pick].be;
            b_off   = off_a[pick];
            b_wdata = wdata_a[pick];
        end

        bankmem_bank #(
            .OFF_W  (OFF_W),
            .DATA_W (DATA_W)
        ) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (b_en),
            .wr    (b_wr),
            .be    (b_be),
            .off   (b_off),
            .wdata (b_wdata),
            .rdata (bank_rd[b])
        );
    end

    // Next state: request tags for the response cycle.
    always_comb begin
        st_d     = st_q;
        st_d.sel = bank_sel;
        for (int p = 0; p < NP; p++) begin
            st_d.vld[p]  = req[p].go && !req[p].wr && req[p].show;
            st_d.err[p]  = req[p].err;
            st_d.bank[p] = bank_a[p];
            st_d.be[p]   = req[p].be;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.sel <= bank_sel;
        end else begin
            st_q <= st_d;
        end
    end

    // Response: selected bank word with disabled lanes cleared.
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            rdata_a[p] = '0;
            if (st_q.vld[p]) begin
                for (int g = 0; g < LANES; g++) begin
                    if (st_q.be[p][g]) begin
                        rdata_a[p][g*LANE_W +: LANE_W] =
                            bank_rd[st_q.bank[p]][g*LANE_W +: LANE_W];
                    end
                end
            end
        end
    end

    assign lp_rdata = rdata_a[0];
    assign rp_rdata = rdata_a[1];
    assign lp_err   = st_q.err[0];
    assign rp_err   = st_q.err[1];

endmodule

// File: rtl/bankmem_dp_chk.sv
module bankmem_dp_chk #(
    parameter  int NB     = 4,
    parameter  int OFF_W  = 8,
    parameter  int DATA_W = 16,
    localparam int BANK_W = $clog2(NB)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NB-1:0]     bank_sel,
    input logic              lp_ce_n,
    input logic              lp_ce,
    input logic              lp_mbx_n,
    input logic              lp_we_n,
    input logic              lp_oe_n,
    input logic              lp_ub_n,
    input logic              lp_lb_n,
    input logic [BANK_W-1:0] lp_bank,
    input logic [DATA_W-1:0] lp_rdata,
    input logic              lp_err,
    input logic              rp_ce_n,
    input logic              rp_ce,
    input logic              rp_mbx_n,
    input logic              rp_we_n,
    input logic              rp_oe_n,
    input logic              rp_ub_n,
    input logic              rp_lb_n,
    input logic [BANK_W-1:0] rp_bank,
    input logic [DATA_W-1:0] rp_rdata,
    input logic              rp_err
);

    logic          l_any;
    logic          r_any;
    logic [NB-1:0] sel_seen;

    assign l_any = !lp_ce_n && lp_ce && lp_mbx_n && (!lp_ub_n || !lp_lb_n);
    assign r_any = !rp_ce_n && rp_ce && rp_mbx_n && (!rp_ub_n || !rp_lb_n);

    always_ff @(posedge clk) begin
        sel_seen <= bank_sel;
    end

    a_r4_left_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        l_any && !bank_sel[lp_bank] |=> lp_err && (lp_rdata == '0));

    a_r4_right_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        r_any && bank_sel[rp_bank] |=> rp_err && (rp_rdata == '0));

    a_r11_left_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !l_any |=> !lp_err && (lp_rdata == '0));

    a_r11_right_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !r_any |=> !rp_err && (rp_rdata == '0));

    a_r6_left_mailbox_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_mbx_n |=> !lp_err);

    a_r9_left_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        l_any && lp_we_n && lp_oe_n |=> lp_rdata == '0);

    a_r8_right_upper_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        r_any && rp_we_n && rp_ub_n |=> rp_rdata[DATA_W-1:DATA_W/2] == '0);

    a_r10_left_switch_drops: assert property (@(posedge clk) disable iff (!rst_n)
        l_any && (bank_sel[lp_bank] != sel_seen[lp_bank]) |=> lp_err);

endmodule

bind bankmem_dp bankmem_dp_chk #(
    .NB     (NB),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
) i_chk (.*);

// File: tb/test_bankmem_dp.sv
module test_bankmem_dp;

    localparam int NB     = 4;
    localparam int OFF_W  = 4;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 1 << OFF_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NB-1:0] bank_sel = 4'b0011;

    logic [1:0]              ce_n, ce, mbx_n, we_n, oe_n, ub_n, lb_n;
    logic [1:0][1:0]         bnk;
    logic [1:0][OFF_W-1:0]   off;
    logic [1:0][DATA_W-1:0]  wd;
    logic [DATA_W-1:0]       lp_rdata, rp_rdata;
    logic                    lp_err, rp_err;

    logic [DATA_W-1:0] model [NB][DEPTH];
    logic [NB-1:0]     prev_sel;
    logic [DATA_W-1:0] exp_d [2];
    logic              exp_e [2];
    int checks = 0;
    int errors = 0;

    always #5ns clk = ~clk;

    bankmem_dp #(.NB(NB), .OFF_W(OFF_W), .DATA_W(DATA_W)) i_bankmem_dp (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .lp_ce_n(ce_n[0]), .lp_ce(ce[0]), .lp_mbx_n(mbx_n[0]), .lp_we_n(we_n[0]),
        .lp_oe_n(oe_n[0]), .lp_ub_n(ub_n[0]), .lp_lb_n(lb_n[0]), .lp_bank(bnk[0]),
        .lp_off(off[0]), .lp_wdata(wd[0]), .lp_rdata(lp_rdata), .lp_err(lp_err),
        .rp_ce_n(ce_n[1]), .rp_ce(ce[1]), .rp_mbx_n(mbx_n[1]), .rp_we_n(we_n[1]),
        .rp_oe_n(oe_n[1]), .rp_ub_n(ub_n[1]), .rp_lb_n(lb_n[1]), .rp_bank(bnk[1]),
        .rp_off(off[1]), .rp_wdata(wd[1]), .rp_rdata(rp_rdata), .rp_err(rp_err)
    );

    function automatic logic [DATA_W-1:0] lane_mask(logic u_n, logic l_n);
        return {{8{!u_n}}, {8{!l_n}}};
    endfunction

    task automatic idle(int p);
        ce_n[p] = 1; ce[p] = 1; mbx_n[p] = 1; we_n[p] = 1; oe_n[p] = 0;
        ub_n[p] = 0; lb_n[p] = 0; bnk[p] = '0; off[p] = '0; wd[p] = '0;
    endtask

    task automatic drv(int p, logic w_n, logic o_n, logic u_n, logic l_n,
                       int b, int o, logic [DATA_W-1:0] d);
        ce_n[p] = 0; ce[p] = 1; mbx_n[p] = 1; we_n[p] = w_n; oe_n[p] = o_n;
        ub_n[p] = u_n; lb_n[p] = l_n; bnk[p] = 2'(b); off[p] = OFF_W'(o); wd[p] = d;
    endtask

    task automatic check(string tag, int p, logic [DATA_W-1:0] gd, logic ge,
                         logic [DATA_W-1:0] ed, logic ee);
        checks++;
        if (gd !== ed || ge !== ee) begin
            errors++;
            $display("FAIL %s port%0d: rdata=%h err=%b expected rdata=%h err=%b",
                     tag, p, gd, ge, ed, ee);
        end
    endtask

    // Computes expectations from the requirements, advances one clock, checks.
    task automatic cycle(string tag);
        logic ok [2];
        for (int p = 0; p < 2; p++) begin
            logic sel, any, own, sw;
            int b;
            b   = int'(bnk[p]);
            sel = !ce_n[p] && ce[p] && mbx_n[p];
            any = sel && (!ub_n[p] || !lb_n[p]);
            own = (p == 0) ? bank_sel[b] : !bank_sel[b];
            sw  = bank_sel[b] != prev_sel[b];
            ok[p]    = any && own && !sw;
            exp_e[p] = any && !ok[p];
            exp_d[p] = '0;
            if (ok[p] && we_n[p] && !oe_n[p])
                exp_d[p] = model[b][off[p]] & lane_mask(ub_n[p], lb_n[p]);
        end
        for (int p = 0; p < 2; p++) begin
            if (ok[p] && !we_n[p]) begin
                logic [DATA_W-1:0] m;
                m = lane_mask(ub_n[p], lb_n[p]);
                model[bnk[p]][off[p]] = (model[bnk[p]][off[p]] & ~m) | (wd[p] & m);
            end
        end
        @(posedge clk);
        prev_sel = bank_sel;
        @(negedge clk);
        check(tag, 0, lp_rdata, lp_err, exp_d[0], exp_e[0]);
        check(tag, 1, rp_rdata, rp_err, exp_d[1], exp_e[1]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4077));
        idle(0); idle(1);
        prev_sel = bank_sel;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 0, lp_rdata, lp_err, '0, 1'b0);
        check("R1", 1, rp_rdata, rp_err, '0, 1'b0);
        rst_n = 1;
        prev_sel = bank_sel;
        @(negedge clk);
        check("R1", 0, lp_rdata, lp_err, '0, 1'b0);
        check("R1", 1, rp_rdata, rp_err, '0, 1'b0);

        // R2 / R12: fill every word through its owner with distinct data.
        for (int b = 0; b < NB; b++) begin
            for (int o = 0; o < DEPTH; o++) begin
                int p;
                p = bank_sel[b] ? 0 : 1;
                idle(1 - p);
                drv(p, 0, 1, 0, 0, b, o, 16'((b << 12) | (o << 4) | 5));
                cycle("R2");
            end
        end
        idle(0); idle(1);
        for (int b = 0; b < NB; b++) begin
            drv(bank_sel[b] ? 0 : 1, 1, 0, 0, 0, b, 7, '0);
            cycle("R12");
            idle(0); idle(1);
        end

        // R3: concurrent work in separate banks.
        drv(0, 1, 0, 0, 0, 0, 3, '0);
        drv(1, 0, 1, 0, 0, 2, 3, 16'hBEEF);
        cycle("R3");
        drv(0, 0, 1, 0, 0, 1, 4, 16'h1234);
        drv(1, 1, 0, 0, 0, 2, 3, '0);
        cycle("R3");

        // R4: left writes and reads a right-owned bank.
        drv(0, 0, 1, 0, 0, 2, 5, 16'hDEAD);
        idle(1);
        cycle("R4");
        drv(0, 1, 0, 0, 0, 3, 5, '0);
        drv(1, 1, 0, 0, 0, 2, 5, '0);
        cycle("R4");

        // R5: each chip enable alone blocks the write.
        drv(0, 0, 1, 0, 0, 0, 9, 16'h5555); ce_n[0] = 1; idle(1);
        cycle("R5");
        drv(0, 0, 1, 0, 0, 0, 9, 16'h6666); ce[0] = 0;
        cycle("R5");
        drv(0, 1, 0, 0, 0, 0, 9, '0); ce[0] = 0;
        cycle("R5");
        drv(0, 1, 0, 0, 0, 0, 9, '0);
        cycle("R5");

        // R6: mailbox select closes the memory path.
        drv(1, 0, 1, 0, 0, 3, 2, 16'h7777); mbx_n[1] = 0; idle(0);
        cycle("R6");
        drv(1, 1, 0, 0, 0, 3, 2, '0); mbx_n[1] = 0;
        cycle("R6");
        drv(1, 1, 0, 0, 0, 3, 2, '0);
        cycle("R6");

        // R7: single-byte writes then a full-word read.
        drv(0, 0, 1, 0, 1, 1, 6, 16'hA1B2); idle(1);
        cycle("R7");
        drv(0, 0, 1, 1, 0, 1, 6, 16'hC3D4);
        cycle("R7");
        drv(0, 1, 0, 0, 0, 1, 6, '0);
        cycle("R7");

        // R8: lane-masked reads and no-lane request.
        drv(0, 1, 0, 0, 1, 1, 6, '0);
        cycle("R8");
        drv(0, 1, 0, 1, 0, 1, 6, '0);
        cycle("R8");
        drv(0, 1, 0, 1, 1, 3, 6, '0);
        cycle("R8");

        // R9: output enable off.
        drv(0, 1, 1, 0, 0, 0, 3, '0);
        cycle("R9");

        // R10: bank 1 moves to the right port while left writes it;
        // right keeps working in bank 3.
        drv(0, 0, 1, 0, 0, 1, 8, 16'hFACE);
        drv(1, 1, 0, 0, 0, 3, 8, '0);
        bank_sel[1] = 1'b0;
        cycle("R10");
        drv(1, 1, 0, 0, 0, 1, 8, '0); idle(0);
        cycle("R10");

        // R11: response lasts one cycle only.
        idle(0); idle(1);
        cycle("R11");

        // Random traffic.
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0) bank_sel[$urandom_range(NB-1)] ^= 1'b1;
            for (int p = 0; p < 2; p++) begin
                ce_n[p]  = ($urandom_range(7) == 0);
                ce[p]    = ($urandom_range(7) != 0);
                mbx_n[p] = ($urandom_range(7) != 0);
                we_n[p]  = 1'($urandom_range(1));
                oe_n[p]  = ($urandom_range(7) == 0);
                ub_n[p]  = ($urandom_range(3) == 0);
                lb_n[p]  = ($urandom_range(3) == 0);
                bnk[p]   = 2'($urandom_range(NB-1));
                off[p]   = OFF_W'($urandom_range(DEPTH-1));
                wd[p]    = 16'($urandom);
            end
            cycle("R12");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule